// File: doc/BRIEF.md
# Handshaked Byte Input Port

This block accepts bytes from a slow external device and hands them to a processor that polls for them. The device places a byte on an 8-bit bus and raises its valid line. The port synchronizes that line, loads the byte into a holding register on its rising edge, raises the accepted line and sets a ready flag in its status register. The device may then drop valid. It must not offer another byte until accepted falls again.

On the processor side, a small register bus exposes two locations. A program reads status and tests the ready flag, looping while the flag is clear. Once the flag is set, it reads the byte. The data read clears the flag by itself, and a status write can also clear it. Once the flag is clear, the port drops accepted, which closes the four-phase handshake and frees the device to send again.

An interrupt-enable bit in the status register lets the port raise an interrupt request whenever a byte is waiting, in place of busy polling.

Top module: `hsin_port`

## Requirements
- R1: After reset, the ready flag, the interrupt enable, the data register, the accepted output and the interrupt output are all 0.
- R2: A rising edge on the device valid line is seen through a two-flop synchronizer. On the third clock edge after valid rises, the byte on the device bus is loaded, the ready flag is set and accepted goes high.
- R3: While the flag is set or accepted is high, a new rising edge on valid is ignored and the data register keeps its byte. That edge is also not remembered after the flag clears.
- R4: Accepted stays high for as long as the flag is set, whether or not valid is still high.
- R5: Accepted falls on the clock edge after the first edge at which the flag reads 0.
- R6: A read of address 0 returns the status byte, with the ready flag in bit 0, interrupt enable in bit 1, and 0 in bits 7..2.
- R7: A read of address 1 returns the held byte and clears the ready flag at that clock edge.
- R8: A write to address 0 loads interrupt enable from data bit 1 and clears the flag when data bit 0 is 1. When data bit 0 is 0, the flag is left unchanged.
- R9: A write to address 1 changes neither the data register nor the flag.
- R10: The interrupt output is 1 exactly when interrupt enable and the ready flag are both 1.
- R11: Holding valid high produces only one capture. Another byte is taken only after valid has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_byte | input | 8 | Byte from the device |
| dev_valid | input | 1 | Device data valid (asynchronous) |
| dev_accept | output | 1 | Byte accepted, back to the device |
| bus_addr | input | 1 | Register address: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 2 | Write data: bit 0 clears the flag, bit 1 is interrupt enable |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench times the synchronizer path to the exact edge. A port that skipped a stage, or that captured on the level of valid instead of its edge, would raise accepted a cycle early or take the same byte twice while valid is held.

It also raises valid again while a byte is still pending. A port that lost the guard would overwrite the held byte, or replay the stale edge once the flag clears.

The release of accepted is checked one edge after the flag clears. Both ways of clearing the flag are used, along with a write of 0 to the flag bit, so that a write that cleared unconditionally, or a data read that did not clear, shows up as a wrong status or a stuck handshake.

// File: rtl/hsin_pkg.sv
package hsin_pkg;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 2;

  // register addresses
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;

  // control bit positions in status
  localparam int BIT_READY = 0;
  localparam int BIT_IEN   = 1;

  function automatic logic [DATA_W-1:0] status_word(input logic ready, input logic ien);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_READY] = ready;
    w[BIT_IEN]   = ien;
    return w;
  endfunction
endpackage

// File: rtl/hsin_sync.sv
module hsin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[LAST];
  end

  assign rise = chain[LAST] & ~last_q;

  // R11: an edge pulse lasts a single cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/hsin_capture.sv
module hsin_capture
  import hsin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_seen,
  input  logic [DATA_W-1:0] din,
  input  logic              clr_req,
  output logic              ready,
  output logic              accept,
  output logic [DATA_W-1:0] held
);
  logic take;
  logic release_hs;

  // capture only when idle: no pending byte and the handshake is closed
  assign take       = edge_seen & ~ready & ~accept;
  assign release_hs = accept & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (take) held <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ready <= 1'b0;
    else if (take)    ready <= 1'b1;
    else if (clr_req) ready <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          accept <= 1'b0;
    else if (take)       accept <= 1'b1;
    else if (release_hs) accept <= 1'b0;
  end

  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ready && accept && held == $past(din)));
  a_r3_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && (ready || accept)) |=> $stable(held));
  a_r4_accept_covers_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> accept);
  a_r5_accept_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(accept) |-> $past(!ready));
endmodule

// File: rtl/hsin_regs.sv
module hsin_regs
  import hsin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] rdata,
  output logic              clr_req,
  output logic              ien
);
  logic rd_data_hit;
  logic wr_stat_hit;

  assign rd_data_hit = rd & (addr == ADDR_DATA);
  assign wr_stat_hit = wr & (addr == ADDR_STATUS);
  assign clr_req     = rd_data_hit | (wr_stat_hit & wdata[BIT_READY]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ien <= 1'b0;
    else if (wr_stat_hit) ien <= wdata[BIT_IEN];
  end

  always_comb begin
    rdata = '0;
    if (rd) rdata = (addr == ADDR_DATA) ? held : status_word(ready, ien);
  end

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_hit |=> !ready);
  a_r8_ien_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_hit |=> ien == $past(wdata[BIT_IEN]));
endmodule

// File: rtl/hsin_port.sv
module hsin_port
  import hsin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        dev_byte,
  input  logic              dev_valid,
  output logic              dev_accept,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic              valid_rise;
  logic              ready;
  logic              clr_req;
  logic              ien;
  logic [DATA_W-1:0] held;

  hsin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dev_valid), .rise(valid_rise)
  );

  hsin_capture u_cap (
    .clk(clk), .rst_n(rst_n), .edge_seen(valid_rise), .din(dev_byte),
    .clr_req(clr_req), .ready(ready), .accept(dev_accept), .held(held)
  );

  hsin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .ready(ready), .held(held), .rdata(bus_rdata),
    .clr_req(clr_req), .ien(ien)
  );

  assign irq = ien & ready;

  a_r10_irq_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dev_accept);
endmodule

// File: tb/hsin_port_test.sv
module hsin_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_byte = '0;
  logic       dev_valid = 1'b0;
  logic       dev_accept;
  logic       bus_addr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic       exp_ien = 1'b0;
  logic [7:0] exp_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsin_port uut (.*);

  function automatic logic [7:0] stat_exp(input logic f, input logic ie);
    return {6'b0, ie, f};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic [1:0] w);
    @(negedge clk); bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // raise valid and check the exact capture edge (R2)
  task automatic send(input logic [7:0] b);
    @(negedge clk); dev_byte = b; dev_valid = 1'b1;
    @(negedge clk); check("R2 accept before sync", dev_accept, 0);
    @(negedge clk); check("R2 accept before sync", dev_accept, 0);
    @(negedge clk); check("R2 accept at third edge", dev_accept, 1);
    exp_byte = b;
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", wd);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 accept", dev_accept, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    bus_read(1'b0, d); check("R1 status", d, 8'h00);
    bus_read(1'b1, d); check("R1 data", d, 8'h00);

    // directed: capture, held valid, bad re-edge, release
    send(8'hA5);
    bus_read(1'b0, d); check("R6 status ready", d, stat_exp(1, 0));
    @(negedge clk); dev_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 accept holds after valid drops", dev_accept, 1);
    dev_byte = 8'h3C; dev_valid = 1'b1;      // out-of-protocol re-edge
    repeat (4) @(negedge clk);
    bus_read(1'b0, d); check("R3 flag still set", d, stat_exp(1, 0));
    bus_write(1'b1, 2'b11);                   // write to data: ignored
    bus_read(1'b0, d); check("R9 flag unchanged", d, stat_exp(1, 1'b0));
    bus_write(1'b0, 2'b10);                   // ien=1, no clear
    check("R8 no clear with bit0=0", irq, 1);
    check("R10 irq high", irq, 1);
    bus_read(1'b1, d); check("R3 held byte kept", d, 8'hA5);
    check("R5 accept one more edge", dev_accept, 1);
    check("R10 irq low after clear", irq, 0);
    @(negedge clk); check("R5 accept dropped", dev_accept, 0);
    repeat (5) @(negedge clk);
    check("R11 no replay while valid held", dev_accept, 0);
    bus_read(1'b0, d); check("R11 status idle", d, stat_exp(0, 1));
    @(negedge clk); dev_valid = 1'b0;
    repeat (3) @(negedge clk);
    exp_ien = 1'b1;

    // random traffic
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b;
      int polls;
      b = 8'($urandom);
      polls = 0;
      send(b);
      if ($urandom % 2) begin @(negedge clk); dev_valid = 1'b0; end
      repeat ($urandom % 4) @(negedge clk);
      do begin bus_read(1'b0, d); polls++; end while (d[0] == 1'b0 && polls < 10);
      check("R6 status polled", d, stat_exp(1, exp_ien));
      check("R10 irq", irq, exp_ien);
      if ($urandom % 2) begin
        logic ie;
        ie = 1'($urandom);
        bus_write(1'b0, {ie, 1'b1});
        exp_ien = ie;
        check("R8 accept one more edge", dev_accept, 1);
        @(negedge clk); check("R5 accept dropped", dev_accept, 0);
        bus_read(1'b0, d); check("R8 write clears flag", d, stat_exp(0, exp_ien));
        bus_read(1'b1, d); check("R7 data after clear", d, exp_byte);
      end else begin
        bus_read(1'b1, d); check("R7 data read", d, exp_byte);
        check("R5 accept one more edge", dev_accept, 1);
        @(negedge clk); check("R5 accept dropped", dev_accept, 0);
        bus_read(1'b0, d); check("R7 read clears flag", d, stat_exp(0, exp_ien));
      end
      check("R10 irq idle", irq, 0);
      @(negedge clk); dev_valid = 1'b0;
      repeat (3) @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule